// File: doc/BRIEF.md
# PHY Register Access Sequencer

This block is the master side of a narrow, indirect path into the configuration registers of a serial-link PHY. The PHY registers are 16 bits wide and are not memory-mapped. They are reached only through a 32-bit control word that the block drives and a 32-bit status word that the PHY returns. The status word carries an acknowledge bit. Each step the master takes is a full four-phase exchange: it raises one control bit, waits for the acknowledge to rise, drops the bit, then waits for the acknowledge to fall.

A single read or write request starts with an address step. A write then has a data-capture step, a write-strobe step and a final all-zero word. A read has a read-strobe step, during which 16 bits of status are captured. The block checks the acknowledge once every `POLL_DIV` cycles, for at most `POLL_MAX` checks per wait. A wait that runs out ends the access with an error.

A third request runs a receiver-reset sequence on the override register at address 0x1005. The sequence reads the register, writes it back with bits 5 and 3 set, stays idle for `HOLD_CYC` cycles, reads it again, and writes it back with those two bits cleared.

Top module: `phy_reg_access`

## Requirements
- R1: While reset is held and just after it is released, `phy_ctrl`, `rdata`, `done`, `error` and `busy` are all zero.
- R2: The control word has a fixed layout. Bits 15:0 carry the address or the data. Bit 16 captures the address, bit 17 captures the data, bit 18 is the write strobe and bit 19 is the read strobe. At most one of bits 19:16 is set at any time, and bits 31:20 are always zero.
- R3: Each access begins with an address step. The block drives the bare address, then the address with bit 16 set, waits for the acknowledge (status bit 16) to go high, drives the bare address again, and waits for the acknowledge to go low. The PHY register touched is the one at the requested address.
- R4: A write continues with a data step in the same four-phase shape using bit 17. Next comes bit 18 on its own until the acknowledge goes high, then the bare data until it goes low, then a zero word. After the write, the PHY register holds `wdata`.
- R5: A read continues with bit 19 on its own until the acknowledge goes high. At that point status bits 15:0 are stored into `rdata`. Then a zero word is driven until the acknowledge goes low.
- R6: The acknowledge is checked once every `POLL_DIV` cycles, for at most `POLL_MAX` checks per wait. If the expected level is not seen, the access ends with `done` and `error` both high and the control word back at zero. If the acknowledge never rises, `done` appears exactly 1 + `POLL_MAX`·`POLL_DIV` cycles after `busy` rises.
- R7: A strobe or capture bit stays set until the acknowledge has been seen high, unless the access ends in a timeout.
- R8: A request is accepted only when the block is idle. `rxrst_en` has priority over `wr_en`, and `wr_en` has priority over `rd_en`. Requests raised while busy are dropped: they cause no PHY access and no `done`.
- R9: `done` is a one-cycle pulse, one per accepted request. `error` is high only together with `done`.
- R10: The receiver-reset request performs five operations in order: a read of 0x1005, a write with bits 5 and 3 set and all other bits kept, an idle of at least `HOLD_CYC` cycles, a second read, and a write with bits 5 and 3 cleared. A single `done` is raised at the end, and `rdata` then holds the second read value.
- R11: A timeout during the receiver-reset sequence aborts the remaining steps and raises `done` with `error`.
- R12: While idle, the control word is zero and `rdata` keeps its last captured value. A write does not change `rdata`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read request, sampled when idle |
| wr_en | input | 1 | Write request, sampled when idle |
| rxrst_en | input | 1 | Receiver-reset sequence request, sampled when idle |
| addr | input | 16 | PHY register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Last data captured from the PHY |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Timeout flag, valid with `done` |
| busy | output | 1 | An access is in progress |
| phy_ctrl | output | 32 | Control word to the PHY |
| phy_stat | input | 32 | Status word from the PHY (acknowledge at bit 16, data at 15:0) |

## Verification
Faults in the step sequencer show up at the PHY side within one poll period: the PHY register ends up at the wrong address or with the wrong value, a strobe overlaps a capture bit, or a strobe drops before the acknowledge. A wrong poll counter shows up as a timeout `done` arriving earlier or later than 1 + `POLL_MAX`·`POLL_DIV` cycles. A wrong composite stage shows up as a missing or extra write of 0x1005, or a bit-5/bit-3 pattern other than set-then-cleared. A corrupted capture shows up as a wrong `rdata` at the `done` pulse of the read.

// File: rtl/phy_reg_access.sv
module phy_reg_access #(
  parameter int          POLL_DIV = 4,
  parameter int          POLL_MAX = 10,
  parameter int          HOLD_CYC = 200,
  parameter logic [15:0] OVR_ADDR = 16'h1005,
  parameter logic [15:0] OVR_MASK = 16'h0028
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rd_en,
  input  logic        wr_en,
  input  logic        rxrst_en,
  input  logic [15:0] addr,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  output logic        done,
  output logic        error,
  output logic        busy,
  output logic [31:0] phy_ctrl,
  input  logic [31:0] phy_stat
);
  localparam int DIVW = (POLL_DIV > 1) ? $clog2(POLL_DIV) : 1;
  localparam int PW   = (POLL_MAX > 1) ? $clog2(POLL_MAX) : 1;
  localparam int HW   = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;

  typedef enum logic [3:0] {
    S_IDLE, S_ASET, S_ACAP, S_AREL, S_WSET, S_WCAP, S_WREL,
    S_WSTB, S_WEND, S_RSTB, S_RREL, S_FIN, S_HOLD
  } st_t;

  st_t             st, nxt;
  logic [15:0]     addr_q, data_q, rdata_q;
  logic            is_wr, comp, done_q, err_q;
  logic [1:0]      cstage;
  logic [DIVW-1:0] div_q;
  logic [PW-1:0]   poll_q;
  logic [HW-1:0]   hold_q;

  wire ack     = phy_stat[16];
  wire waiting = st inside {S_ACAP, S_AREL, S_WCAP, S_WREL, S_WSTB, S_WEND, S_RSTB, S_RREL};
  wire want_hi = st inside {S_ACAP, S_WCAP, S_WSTB, S_RSTB};
  wire sample  = waiting && (div_q == DIVW'(POLL_DIV - 1));
  wire hit     = sample && (ack == want_hi);
  wire tmo     = sample && !hit && (poll_q == PW'(POLL_MAX - 1));

  logic unused_stat;
  assign unused_stat = ^phy_stat[31:17];

  always_comb begin
    case (st)
      S_ASET, S_AREL:         phy_ctrl = {16'h0, addr_q};
      S_ACAP:                 phy_ctrl = {12'h0, 4'b0001, addr_q};
      S_WSET, S_WREL, S_WEND: phy_ctrl = {16'h0, data_q};
      S_WCAP:                 phy_ctrl = {12'h0, 4'b0010, data_q};
      S_WSTB:                 phy_ctrl = 32'h0004_0000;
      S_RSTB:                 phy_ctrl = 32'h0008_0000;
      default:                phy_ctrl = 32'h0;
    endcase
  end

  always_comb begin
    case (st)
      S_ACAP:  nxt = S_AREL;
      S_AREL:  nxt = is_wr ? S_WSET : S_RSTB;
      S_WCAP:  nxt = S_WREL;
      S_WREL:  nxt = S_WSTB;
      S_WSTB:  nxt = S_WEND;
      S_RSTB:  nxt = S_RREL;
      default: nxt = S_FIN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      addr_q  <= '0;
      data_q  <= '0;
      rdata_q <= '0;
      is_wr   <= 1'b0;
      comp    <= 1'b0;
      cstage  <= '0;
      div_q   <= '0;
      poll_q  <= '0;
      hold_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (waiting) begin
        if (hit) begin
          st     <= nxt;
          div_q  <= '0;
          poll_q <= '0;
          if (st == S_RSTB) rdata_q <= phy_stat[15:0];
        end else if (tmo) begin
          st     <= S_IDLE;
          comp   <= 1'b0;
          done_q <= 1'b1;
          err_q  <= 1'b1;
          div_q  <= '0;
          poll_q <= '0;
        end else if (sample) begin
          poll_q <= poll_q + 1'b1;
          div_q  <= '0;
        end else begin
          div_q <= div_q + 1'b1;
        end
      end else begin
        case (st)
          S_IDLE: begin
            if (rxrst_en) begin
              comp   <= 1'b1;
              cstage <= 2'd0;
              is_wr  <= 1'b0;
              addr_q <= OVR_ADDR;
              st     <= S_ASET;
            end else if (wr_en) begin
              is_wr  <= 1'b1;
              addr_q <= addr;
              data_q <= wdata;
              st     <= S_ASET;
            end else if (rd_en) begin
              is_wr  <= 1'b0;
              addr_q <= addr;
              st     <= S_ASET;
            end
          end
          S_ASET: st <= S_ACAP;
          S_WSET: st <= S_WCAP;
          S_FIN: begin
            if (!comp) begin
              st     <= S_IDLE;
              done_q <= 1'b1;
            end else begin
              case (cstage)
                2'd0: begin
                  data_q <= rdata_q | OVR_MASK;
                  is_wr  <= 1'b1;
                  cstage <= 2'd1;
                  st     <= S_ASET;
                end
                2'd1: begin
                  cstage <= 2'd2;
                  hold_q <= '0;
                  st     <= S_HOLD;
                end
                2'd2: begin
                  data_q <= rdata_q & ~OVR_MASK;
                  is_wr  <= 1'b1;
                  cstage <= 2'd3;
                  st     <= S_ASET;
                end
                default: begin
                  comp   <= 1'b0;
                  st     <= S_IDLE;
                  done_q <= 1'b1;
                end
              endcase
            end
          end
          S_HOLD: begin
            if (hold_q == HW'(HOLD_CYC - 1)) begin
              is_wr <= 1'b0;
              st    <= S_ASET;
            end else begin
              hold_q <= hold_q + 1'b1;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assign rdata = rdata_q;
  assign done  = done_q;
  assign error = err_q;
  assign busy  = (st != S_IDLE);
endmodule

module phy_reg_access_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        error,
  input logic [15:0] rdata,
  input logic [31:0] phy_ctrl,
  input logic [31:0] phy_stat
);
  // R2
  ctrl_layout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(phy_ctrl[19:16]) && (phy_ctrl[31:20] == 12'h0));

  // R7
  strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|phy_ctrl[19:16]) && !phy_stat[16]) |=> ((|phy_ctrl[19:16]) || error));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> done);

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (phy_ctrl == 32'h0));

  // R12
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(rdata));
endmodule

bind phy_reg_access phy_reg_access_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .error(error),
  .rdata(rdata), .phy_ctrl(phy_ctrl), .phy_stat(phy_stat)
);

// File: tb/phy_reg_access_bench.sv
module phy_reg_access_bench;
  localparam int POLL_DIV = 4;
  localparam int POLL_MAX = 10;
  localparam int HOLD_CYC = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_en = 1'b0, wr_en = 1'b0, rxrst_en = 1'b0;
  logic [15:0] addr = '0, wdata = '0;
  logic [15:0] rdata;
  logic done, error, busy;
  logic [31:0] phy_ctrl, phy_stat;

  always #4 clk = ~clk;

  phy_reg_access #(.POLL_DIV(POLL_DIV), .POLL_MAX(POLL_MAX), .HOLD_CYC(HOLD_CYC)) u_phy_reg_access (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .rxrst_en(rxrst_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .done(done), .error(error),
    .busy(busy), .phy_ctrl(phy_ctrl), .phy_stat(phy_stat));

  int checks = 0;
  int fails  = 0;

  // PHY slave model
  int          lat  = 1;
  int          mode = 0;
  int          cyc  = 0;
  logic [7:0]  ack_pipe = '0;
  logic [15:0] addr_l = '0, data_l = '0, rd_l = '0;
  logic        prev_wr = 1'b0;
  logic [15:0] mem [logic [15:0]];
  logic [15:0] wl_a[$];
  logic [15:0] wl_d[$];
  int          wl_t[$];
  logic        ack_m;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    ack_pipe <= {ack_pipe[6:0], |phy_ctrl[19:16]};
    if (phy_ctrl[16]) addr_l <= phy_ctrl[15:0];
    if (phy_ctrl[17]) data_l <= phy_ctrl[15:0];
    if (phy_ctrl[18] && !prev_wr) begin
      mem[addr_l] = data_l;
      wl_a.push_back(addr_l);
      wl_d.push_back(data_l);
      wl_t.push_back(cyc);
    end
    prev_wr <= phy_ctrl[18];
    if (phy_ctrl[19]) rd_l <= mem.exists(addr_l) ? mem[addr_l] : 16'h0;
  end

  assign ack_m    = (mode == 1) ? 1'b0 : (mode == 2) ? 1'b1 : ack_pipe[lat-1];
  assign phy_stat = {15'h0, ack_m, rd_l};

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // scoreboard
  logic        q_chk[$];
  logic [15:0] q_rd[$];
  logic        q_err[$];
  string       q_tag[$];

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (q_chk.size() == 0) begin
        check(1'b0, "R8/R9 unexpected done", 32'(done), 32'h0);
      end else begin
        automatic logic        c = q_chk.pop_front();
        automatic logic [15:0] r = q_rd.pop_front();
        automatic logic        e = q_err.pop_front();
        automatic string       t = q_tag.pop_front();
        check(error == e, {t, " error"}, 32'(error), 32'(e));
        if (c) check(rdata == r, {t, " rdata"}, 32'(rdata), 32'(r));
      end
    end
  end

  task automatic op(input int kind, input logic [15:0] a, input logic [15:0] d,
                    input logic c, input logic [15:0] exp, input logic eerr,
                    input string tag, output int ncyc);
    q_chk.push_back(c); q_rd.push_back(exp); q_err.push_back(eerr); q_tag.push_back(tag);
    @(negedge clk);
    addr = a; wdata = d;
    rd_en = (kind == 0); wr_en = (kind == 1); rxrst_en = (kind == 2);
    ncyc = 0;
    do begin
      @(negedge clk);
      ncyc++;
      if (ncyc == 1) begin rd_en = 0; wr_en = 0; rxrst_en = 0; end
    end while (!done);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n, base, t0;
    logic [15:0] keep;
    repeat (5) @(negedge clk);
    // R1 reset state
    check(phy_ctrl == 0 && rdata == 0 && !done && !error && !busy, "R1 in reset",
          {phy_ctrl[19:16], rdata, 9'h0, done, error, busy}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(phy_ctrl == 0 && !busy && !done, "R1 after release", phy_ctrl, 32'h0);

    // R3 R4 R5 short ack latency
    lat = 1;
    op(1, 16'h0010, 16'hBEEF, 0, 0, 0, "R4 wr 0010", n);
    check(wl_a[$] == 16'h0010 && wl_d[$] == 16'hBEEF, "R3/R4 phy reg", {wl_a[$], wl_d[$]}, 32'h0010BEEF);
    check(phy_ctrl == 0, "R4 ends zero", phy_ctrl, 0);
    op(0, 16'h0010, 0, 1, 16'hBEEF, 0, "R5 rd 0010", n);
    // R12 write leaves rdata
    op(1, 16'h0041, 16'h0BEE, 0, 0, 0, "R4 wr 0041", n);
    check(rdata == 16'hBEEF, "R12 rdata kept over write", rdata, 16'hBEEF);

    // long latency: several polls per wait
    lat = 6;
    op(1, 16'h0200, 16'h1234, 0, 0, 0, "R6 wr slow", n);
    op(0, 16'h0200, 0, 1, 16'h1234, 0, "R6 rd slow", n);
    op(1, 16'hFFFF, 16'h8001, 0, 0, 0, "R4 wr FFFF", n);
    op(0, 16'hFFFF, 0, 1, 16'h8001, 0, "R5 rd FFFF", n);
    check(wl_a[$] == 16'hFFFF, "R3 top address", wl_a[$], 16'hFFFF);
    lat = 2;

    // R8 requests while busy are dropped
    base = wl_a.size();
    q_chk.push_back(0); q_rd.push_back(0); q_err.push_back(0); q_tag.push_back("R8 first");
    @(negedge clk);
    addr = 16'h0040; wdata = 16'h1111; wr_en = 1;
    @(negedge clk); wr_en = 0;
    repeat (4) @(negedge clk);
    addr = 16'h0041; wdata = 16'h2222; wr_en = 1; rd_en = 1; rxrst_en = 1;
    @(negedge clk); wr_en = 0; rd_en = 0; rxrst_en = 0;
    while (!done) @(negedge clk);
    repeat (20) @(negedge clk);
    check(wl_a.size() == base + 1, "R8 single PHY write", wl_a.size() - base, 1);
    op(0, 16'h0041, 0, 1, 16'h0BEE, 0, "R8 dropped write", n);

    // R8 priority: write over read
    base = wl_a.size();
    q_chk.push_back(0); q_rd.push_back(0); q_err.push_back(0); q_tag.push_back("R8 prio");
    @(negedge clk);
    addr = 16'h0050; wdata = 16'h5555; wr_en = 1; rd_en = 1;
    @(negedge clk); wr_en = 0; rd_en = 0;
    while (!done) @(negedge clk);
    repeat (3) @(negedge clk);
    check(wl_a.size() == base + 1, "R8 write wins", wl_a.size() - base, 1);
    op(0, 16'h0050, 0, 1, 16'h5555, 0, "R8 prio readback", n);

    // R10 receiver reset
    mem[16'h1005] = 16'hA5D7;
    base = wl_a.size();
    op(2, 0, 0, 1, 16'hA5FF, 0, "R10 rxrst", n);
    check(wl_a.size() == base + 2, "R10 two writes", wl_a.size() - base, 2);
    if (wl_a.size() == base + 2) begin
      check(wl_a[base] == 16'h1005 && wl_d[base] == 16'hA5FF, "R10 set write", {wl_a[base], wl_d[base]}, 32'h1005A5FF);
      check(wl_a[base+1] == 16'h1005 && wl_d[base+1] == 16'hA5D7, "R10 clear write", {wl_a[base+1], wl_d[base+1]}, 32'h1005A5D7);
      check(wl_t[base+1] - wl_t[base] > HOLD_CYC, "R10 hold gap", wl_t[base+1] - wl_t[base], HOLD_CYC);
    end
    mem[16'h1005] = 16'h0028;
    base = wl_a.size();
    op(2, 0, 0, 1, 16'h0028, 0, "R10 rxrst bits set", n);
    if (wl_a.size() == base + 2)
      check(wl_d[base] == 16'h0028 && wl_d[base+1] == 16'h0000, "R10 set/clear", {wl_d[base], wl_d[base+1]}, 32'h00280000);
    else
      check(0, "R10 write count", wl_a.size() - base, 2);

    // R6 timeout, ack never rises
    mode = 1;
    keep = rdata;
    op(0, 16'h0010, 0, 1, keep, 1, "R6 dead rd", n);
    check(n == 2 + POLL_MAX * POLL_DIV, "R6 timeout latency", n, 2 + POLL_MAX * POLL_DIV);
    check(phy_ctrl == 0 && !busy, "R6 ctrl zero after timeout", phy_ctrl, 0);
    // R6 ack stuck high
    mode = 2;
    base = wl_a.size();
    op(1, 16'h0060, 16'h6666, 0, 0, 1, "R6 stuck wr", n);
    check(wl_a.size() == base, "R6 no write on timeout", wl_a.size() - base, 0);
    // R11 composite aborted
    mode = 1;
    op(2, 0, 0, 0, 0, 1, "R11 rxrst dead", n);
    check(wl_a.size() == base, "R11 no writes", wl_a.size() - base, 0);
    mode = 0;
    repeat (10) @(negedge clk);
    op(0, 16'h0010, 0, 1, 16'hBEEF, 0, "R6 recovery rd", n);

    repeat (5) @(negedge clk);
    check(q_chk.size() == 0, "R9 all done pulses seen", q_chk.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule